// File: doc/BRIEF.md
# Exception Context Frame Push Sequencer

On exception entry a small processor core must save its interrupted context on the active stack. This block takes the current stack pointer, the seven integer context words, the status word, a file of sixteen 64-bit floating-point registers with their status word, and the security and FP control bits. From these it picks one of three frame sizes, realigns and lowers the stack pointer, and sends the frame out one 32-bit word at a time. It also reports the resulting stack pointer, any fault, whether the FP state may now be wiped, and the exception-return code.

The core pulses `start` while the sequencer is idle. The control and address inputs are sampled on that edge. The register-value inputs (`ctx_words`, `status_in`, `dregs`, `fpscr`) must stay stable until `done`. The write port is valid/ready. `wr_valid` rises the cycle after `start` and holds its address and data steady until `wr_ready` is seen high on a clock edge. The sink may hold `wr_ready` low for any number of cycles. `wr_err` is sampled only on an accepted beat. After the last beat, or after an aborting beat, `done` is high for one cycle. The result outputs are valid during that cycle.

Top module: `exc_frame_push`

## Requirements
- R1: The frame is 32 bytes when `fp_active` is low, or when `is_secure` and `ns_cp10_ok` are both low. Otherwise it is 168 bytes when `is_secure` and `fp_treat_secure` are both high, and 104 bytes in every other case.
- R2: When `align_req` is high and bit 2 of `sp_in` is set, the pointer is first rounded down to a multiple of 8 and bit 9 of the stacked status word is forced to 1. The frame size is then subtracted. `sp_out` at `done` equals the resulting frame base.
- R3: Beats 0 to 6 carry `ctx_words` word i (bits 32i+31:32i) to base+4i, so word 6, the return address, lands at +24. Beat 7 carries the status word to +28. In that word, bit 20 is replaced by (`is_secure` AND `sfp_active`) and bit 9 follows R2.
- R4: In an eager FP save, beats 8 onward write each double k in turn, low word then high word, at base+0x20+8k, plus 8 more bytes when k is 8 or above. A final beat writes `fpscr` at base+0x60. The small frame covers k = 0..7 and the large frame covers k = 0..15.
- R5: With `fp_active` high, a set `lazy_pending` together with `has_sec_ext` raises `fault_secure` and writes no FP state. This check takes priority over R6.
- R6: Otherwise, with `fp_active` high, `is_secure` low and `ns_cp10_ok` low, `fault_nocp` is raised and only the 8 basic words are written.
- R7: When no fault from R5 or R6 applies and `lazy_en` is high, no FP words are written and no fault is raised.
- R8: In an eager save with `cpacr_ok` low, the sequence ends after the 8 basic words with `fault_nocp` high and `stack_ok` low. If a basic beat failed first, no `fault_nocp` is raised.
- R9: `fp_clear` pulses with `done` only after an eager save in which every beat, including the `fpscr` beat, completed without `wr_err`.
- R10: `exc_ret` equals 0xFFFFFF80, with bit 6 equal to `is_secure`, bit 5 set, and bit 4 set only when `fp_active` was low.
- R11: A beat completes only on a clock edge where `wr_valid` and `wr_ready` are both high. While stalled, `wr_valid`, `wr_addr` and `wr_data` hold.
- R12: A beat accepted with `wr_err` high is the last beat. `stack_ok` is then low, and `sp_out` still reports the frame base.
- R13: `done` lasts exactly one cycle. A `start` pulse while a sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame push (honoured only when idle) |
| sp_in | input | 32 | Stack pointer before entry |
| align_req | input | 1 | Request 8-byte realignment |
| ctx_words | input | 224 | Seven integer context words; word 6 is the return address |
| status_in | input | 32 | Status word before entry |
| dregs | input | 1024 | Sixteen 64-bit FP registers, register k at bits 64k+63:64k |
| fpscr | input | 32 | FP status word |
| is_secure | input | 1 | Core is in the secure state |
| fp_active | input | 1 | FP context is live |
| sfp_active | input | 1 | Secure FP context flag |
| ns_cp10_ok | input | 1 | Non-secure side may use the FP unit |
| fp_treat_secure | input | 1 | Save the extended FP frame |
| lazy_pending | input | 1 | A deferred FP save is still outstanding |
| has_sec_ext | input | 1 | Security extension present |
| lazy_en | input | 1 | Deferred FP saving enabled |
| cpacr_ok | input | 1 | Current mode may access the FP unit |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Sink accepts the beat |
| wr_addr | output | 32 | Byte address of the beat |
| wr_data | output | 32 | Data of the beat |
| wr_err | input | 1 | Accepted beat failed |
| done | output | 1 | One-cycle end-of-sequence pulse |
| sp_out | output | 32 | New stack pointer (frame base) |
| stack_ok | output | 1 | All required beats succeeded |
| fault_secure | output | 1 | Secure fault, with done |
| fault_nocp | output | 1 | No-coprocessor usage fault, with done |
| fp_clear | output | 1 | FP registers and FP status may be zeroed, with done |
| exc_ret | output | 32 | Exception-return code |

## Verification
On every cycle, the embedded properties check that a stalled beat holds steady and that each address is word aligned and lies inside the chosen frame. They also check that the frame size is one of the three legal values, that the beat index never passes the last beat, that `done` is a single-cycle pulse, that the two faults never coincide, and that `fp_clear` never appears without `stack_ok`. Only the bench's scenarios can show that the fault priority is right. The same holds for the reserved-slot skip and the exact beat count of each mode. They also cover the suppressed fault after an early write error, the realignment arithmetic, and that a `start` arriving while busy is ignored.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned CTX_WORDS   = 7;
  localparam int unsigned BASIC_WORDS = CTX_WORDS + 1;
  localparam int unsigned ND_MAX      = 16;
  localparam int unsigned ND_SMALL    = ND_MAX / 2;
  localparam int unsigned FSZ_BASIC   = 32;
  localparam int unsigned FSZ_FP      = 104;
  localparam int unsigned FSZ_FPX     = 168;
  localparam int unsigned FSZ_W       = 8;
  localparam int unsigned FP_BASE_OFS = 'h20;
  localparam int unsigned FPSCR_OFS   = 'h60;
  localparam int unsigned REALIGN_BIT = 9;
  localparam int unsigned SFPA_BIT    = 20;
  localparam int unsigned MAX_WORDS   = BASIC_WORDS + 2 * ND_MAX + 1;
  localparam int unsigned IDX_W       = $clog2(MAX_WORDS + 1);
  localparam logic [WORD_W-1:0] RET_BASE = 32'hFFFF_FF80;

  typedef enum logic [1:0] {
    FPA_NONE   = 2'd0,
    FPA_EAGER  = 2'd1,
    FPA_SECFLT = 2'd2,
    FPA_NOCP   = 2'd3
  } fp_act_e;

  typedef struct packed {
    logic [WORD_W-1:0] frame_ptr;
    logic [FSZ_W-1:0]  frame_size;
    logic [WORD_W-1:0] status;
    fp_act_e           act;
    logic              big;
    logic [WORD_W-1:0] ret_code;
  } plan_t;
endpackage

// File: rtl/exc_frame_plan.sv
module exc_frame_plan
  import exc_frame_pkg::*;
(
  input  logic [WORD_W-1:0] sp_in,
  input  logic              align_req,
  input  logic [WORD_W-1:0] status_in,
  input  logic              is_secure,
  input  logic              fp_active,
  input  logic              sfp_active,
  input  logic              ns_cp10_ok,
  input  logic              fp_treat_secure,
  input  logic              lazy_pending,
  input  logic              has_sec_ext,
  input  logic              lazy_en,
  output plan_t             plan
);
  logic              fp_room;
  logic              realign;
  logic [WORD_W-1:0] base;
  logic [FSZ_W-1:0]  fsz;

  always_comb begin
    fp_room = fp_active && (is_secure || ns_cp10_ok);
    if (!fp_room)                          fsz = FSZ_W'(FSZ_BASIC);
    else if (is_secure && fp_treat_secure) fsz = FSZ_W'(FSZ_FPX);
    else                                   fsz = FSZ_W'(FSZ_FP);

    realign = align_req && sp_in[2];
    base    = realign ? {sp_in[WORD_W-1:3], 3'b000} : sp_in;

    plan.frame_size = fsz;
    plan.frame_ptr  = base - WORD_W'(fsz);
    plan.big        = (fsz == FSZ_W'(FSZ_FPX));

    plan.status              = status_in;
    plan.status[REALIGN_BIT] = status_in[REALIGN_BIT] | realign;
    plan.status[SFPA_BIT]    = is_secure && sfp_active;

    // priority: secure fault, then non-secure access fault, then lazy/eager
    if (!fp_active)                       plan.act = FPA_NONE;
    else if (lazy_pending && has_sec_ext) plan.act = FPA_SECFLT;
    else if (!is_secure && !ns_cp10_ok)   plan.act = FPA_NOCP;
    else if (lazy_en)                     plan.act = FPA_NONE;
    else                                  plan.act = FPA_EAGER;

    plan.ret_code    = RET_BASE;
    plan.ret_code[6] = is_secure;
    plan.ret_code[5] = 1'b1;
    plan.ret_code[4] = !fp_active;
  end
endmodule

// File: rtl/exc_frame_slot.sv
module exc_frame_slot
  import exc_frame_pkg::*;
(
  input  logic [IDX_W-1:0]            idx,
  input  logic [WORD_W-1:0]           frame_ptr,
  input  logic                        big,
  input  logic [CTX_WORDS*WORD_W-1:0] ctx_words,
  input  logic [WORD_W-1:0]           status,
  input  logic [ND_MAX*64-1:0]        dregs,
  input  logic [WORD_W-1:0]           fpscr,
  output logic [WORD_W-1:0]           addr,
  output logic [WORD_W-1:0]           data
);
  localparam int unsigned K_W = IDX_W - 1;

  logic [IDX_W-1:0]  j;
  logic [K_W-1:0]    k;
  logic [IDX_W-1:0]  fpscr_j;
  logic [WORD_W-1:0] ofs;

  always_comb begin
    j       = idx - IDX_W'(BASIC_WORDS);
    k       = j[IDX_W-1:1];
    fpscr_j = big ? IDX_W'(2 * ND_MAX) : IDX_W'(2 * ND_SMALL);
    ofs     = '0;
    data    = '0;
    if (idx < IDX_W'(CTX_WORDS)) begin
      ofs  = WORD_W'(idx) << 2;
      data = ctx_words[32'(idx) * WORD_W +: WORD_W];
    end else if (idx == IDX_W'(CTX_WORDS)) begin
      ofs  = WORD_W'(CTX_WORDS * 4);
      data = status;
    end else if (j == fpscr_j) begin
      ofs  = WORD_W'(FPSCR_OFS);
      data = fpscr;
    end else if (k < K_W'(ND_MAX)) begin
      ofs = WORD_W'(FP_BASE_OFS) + (WORD_W'(k) << 3) + (j[0] ? WORD_W'(4) : WORD_W'(0));
      if (k >= K_W'(ND_SMALL)) ofs = ofs + WORD_W'(8);
      data = dregs[32'(k) * 64 + (j[0] ? 32 : 0) +: WORD_W];
    end
    addr = frame_ptr + ofs;
  end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  plan_t            plan_in,
  input  logic             cpacr_ok,
  input  logic             wr_ready,
  input  logic             wr_err,
  output plan_t            plan_q,
  output logic [IDX_W-1:0] idx,
  output logic             wr_valid,
  output logic             done,
  output logic             stack_ok,
  output logic             fault_secure,
  output logic             fault_nocp,
  output logic             fp_clear
);
  localparam logic [IDX_W-1:0] LAST_BASIC = IDX_W'(BASIC_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_SMALL = IDX_W'(BASIC_WORDS + 2 * ND_SMALL);
  localparam logic [IDX_W-1:0] LAST_BIG   = IDX_W'(BASIC_WORDS + 2 * ND_MAX);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_DONE} st_e;
  st_e              st;
  logic             cpacr_q, ok_q, sec_q, nocp_q, clr_q;
  logic [IDX_W-1:0] last_idx;
  logic             eager;

  always_comb begin
    eager = (plan_q.act == FPA_EAGER);
    if (eager && cpacr_q) last_idx = plan_q.big ? LAST_BIG : LAST_SMALL;
    else                  last_idx = LAST_BASIC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      plan_q  <= '0;
      idx     <= '0;
      cpacr_q <= 1'b0;
      ok_q    <= 1'b0;
      sec_q   <= 1'b0;
      nocp_q  <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          plan_q  <= plan_in;
          cpacr_q <= cpacr_ok;
          idx     <= '0;
          ok_q    <= 1'b1;
          sec_q   <= (plan_in.act == FPA_SECFLT);
          nocp_q  <= (plan_in.act == FPA_NOCP);
          clr_q   <= 1'b0;
          st      <= S_PUSH;
        end
        S_PUSH: if (wr_ready) begin
          if (wr_err) begin
            ok_q <= 1'b0;
            st   <= S_DONE;
          end else if (idx == LAST_BASIC && eager && !cpacr_q) begin
            nocp_q <= 1'b1;
            ok_q   <= 1'b0;
            st     <= S_DONE;
          end else if (idx == last_idx) begin
            clr_q <= eager;
            st    <= S_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wr_valid     = (st == S_PUSH);
  assign done         = (st == S_DONE);
  assign stack_ok     = ok_q;
  assign fault_secure = done && sec_q;
  assign fault_nocp   = done && nocp_q;
  assign fp_clear     = done && clr_q;

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_secure && fault_nocp));
  p_clear_needs_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fp_clear |-> stack_ok);
  p_size_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (plan_q.frame_size == FSZ_W'(FSZ_BASIC) ||
                  plan_q.frame_size == FSZ_W'(FSZ_FP) ||
                  plan_q.frame_size == FSZ_W'(FSZ_FPX)));
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> idx <= last_idx);
  p_stall_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(idx));
endmodule

// File: rtl/exc_frame_push.sv
module exc_frame_push
  import exc_frame_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [WORD_W-1:0]           sp_in,
  input  logic                        align_req,
  input  logic [CTX_WORDS*WORD_W-1:0] ctx_words,
  input  logic [WORD_W-1:0]           status_in,
  input  logic [ND_MAX*64-1:0]        dregs,
  input  logic [WORD_W-1:0]           fpscr,
  input  logic                        is_secure,
  input  logic                        fp_active,
  input  logic                        sfp_active,
  input  logic                        ns_cp10_ok,
  input  logic                        fp_treat_secure,
  input  logic                        lazy_pending,
  input  logic                        has_sec_ext,
  input  logic                        lazy_en,
  input  logic                        cpacr_ok,
  output logic                        wr_valid,
  input  logic                        wr_ready,
  output logic [WORD_W-1:0]           wr_addr,
  output logic [WORD_W-1:0]           wr_data,
  input  logic                        wr_err,
  output logic                        done,
  output logic [WORD_W-1:0]           sp_out,
  output logic                        stack_ok,
  output logic                        fault_secure,
  output logic                        fault_nocp,
  output logic                        fp_clear,
  output logic [WORD_W-1:0]           exc_ret
);
  plan_t            plan_d, plan_q;
  logic [IDX_W-1:0] idx;

  exc_frame_plan u_plan (
    .sp_in(sp_in), .align_req(align_req), .status_in(status_in),
    .is_secure(is_secure), .fp_active(fp_active), .sfp_active(sfp_active),
    .ns_cp10_ok(ns_cp10_ok), .fp_treat_secure(fp_treat_secure),
    .lazy_pending(lazy_pending), .has_sec_ext(has_sec_ext),
    .lazy_en(lazy_en), .plan(plan_d)
  );

  exc_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .plan_in(plan_d),
    .cpacr_ok(cpacr_ok), .wr_ready(wr_ready), .wr_err(wr_err),
    .plan_q(plan_q), .idx(idx), .wr_valid(wr_valid), .done(done),
    .stack_ok(stack_ok), .fault_secure(fault_secure),
    .fault_nocp(fault_nocp), .fp_clear(fp_clear)
  );

  exc_frame_slot u_slot (
    .idx(idx), .frame_ptr(plan_q.frame_ptr), .big(plan_q.big),
    .ctx_words(ctx_words), .status(plan_q.status), .dregs(dregs),
    .fpscr(fpscr), .addr(wr_addr), .data(wr_data)
  );

  assign sp_out  = plan_q.frame_ptr;
  assign exc_ret = plan_q.ret_code;

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00);
  p_addr_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr - sp_out) < WORD_W'(plan_q.frame_size));
endmodule

// File: tb/sim_exc_frame_push.sv
module sim_exc_frame_push;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] sp_in = 0, status_in = 0, fpscr = 0;
  logic align_req = 0;
  logic [223:0] ctx_words = 0;
  logic [1023:0] dregs = 0;
  logic is_secure = 0, fp_active = 0, sfp_active = 0, ns_cp10_ok = 0;
  logic fp_treat_secure = 0, lazy_pending = 0, has_sec_ext = 0, lazy_en = 0, cpacr_ok = 0;
  logic wr_valid, wr_ready = 0, wr_err = 0, done, stack_ok, fault_secure, fault_nocp, fp_clear;
  logic [31:0] wr_addr, wr_data, sp_out, exc_ret;

  int total = 0, fails = 0, cycles = 0;
  int err_at = -1;
  bit poke = 0;
  bit full_ready = 0;

  always #10 clk = ~clk;

  exc_frame_push u0 (.*);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; total++;
      $display("FAIL watchdog act=%0d exp=finish", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---- expected model from the requirements ----
  function automatic int e_size();
    if (!fp_active || (!is_secure && !ns_cp10_ok)) return 32;       // R1
    return (is_secure && fp_treat_secure) ? 168 : 104;
  endfunction
  function automatic bit e_realign(); return align_req && sp_in[2]; endfunction
  function automatic logic [31:0] e_base();
    logic [31:0] b = e_realign() ? (sp_in & ~32'h7) : sp_in;
    return b - 32'(e_size());
  endfunction
  function automatic logic [31:0] e_status();
    logic [31:0] s = status_in;
    if (e_realign()) s[9] = 1'b1;
    s[20] = is_secure && sfp_active;
    return s;
  endfunction
  // 0 none, 1 eager, 2 secure fault, 3 nocp
  function automatic int e_mode();
    if (!fp_active) return 0;
    if (lazy_pending && has_sec_ext) return 2;
    if (!is_secure && !ns_cp10_ok) return 3;
    if (lazy_en) return 0;
    return 1;
  endfunction
  function automatic int e_nd(); return (e_size() == 168) ? 16 : 8; endfunction
  function automatic int e_nominal();
    return (e_mode() == 1 && cpacr_ok) ? 8 + 2 * e_nd() + 1 : 8;
  endfunction
  function automatic logic [31:0] e_ofs(int i);
    int j, k;
    if (i < 8) return 32'(4 * i);
    j = i - 8;
    if (j == 2 * e_nd()) return 32'h60;
    k = j / 2;
    return 32'(32 + 8 * k + ((k >= 8) ? 8 : 0) + 4 * (j % 2));
  endfunction
  function automatic logic [31:0] e_data(int i);
    int j;
    if (i < 7) return ctx_words[i*32 +: 32];
    if (i == 7) return e_status();
    j = i - 8;
    if (j == 2 * e_nd()) return fpscr;
    return dregs[(j/2)*64 + (j%2)*32 +: 32];
  endfunction

  task automatic randomize_data();
    for (int i = 0; i < 7; i++) ctx_words[i*32 +: 32] = $urandom;
    for (int i = 0; i < 32; i++) dregs[i*32 +: 32] = $urandom;
    status_in = $urandom;
    fpscr = $urandom;
    sp_in = {$urandom, 2'b00};
    align_req = 1;
  endtask

  task automatic clear_ctl();
    is_secure = 0; fp_active = 0; sfp_active = 0; ns_cp10_ok = 0; fp_treat_secure = 0;
    lazy_pending = 0; has_sec_ext = 0; lazy_en = 0; cpacr_ok = 1;
    err_at = -1; poke = 0; full_ready = 0;
  endtask

  task automatic run_case(string nm);
    int n = 0, cyc = 0;
    bit got = 0, rdy;
    int nexp, mode;
    logic [31:0] sp_keep;
    mode = e_mode();
    nexp = (err_at >= 0) ? err_at + 1 : e_nominal();
    sp_keep = sp_in;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!got && cyc < 3000) begin
      sp_in = sp_keep;
      if (done) begin
        got = 1;
        wr_ready = 0; wr_err = 0;
      end else begin
        if (wr_valid) begin
          rdy = full_ready || (($urandom % 4) != 0);
          if (rdy) begin
            chk(wr_addr == e_base() + e_ofs(n), {nm, " R3/R4 addr"}, wr_addr, e_base() + e_ofs(n));
            chk(wr_data == e_data(n), {nm, " R3/R4 data"}, wr_data, e_data(n));
            wr_err = (n == err_at);
            n++;
          end else wr_err = 0;
          wr_ready = rdy;
        end else begin
          wr_ready = 0; wr_err = 0;
        end
        start = 0;
        if (poke && cyc == 2) begin
          start = 1;                       // R13 start while busy
          sp_in = sp_keep ^ 32'h0000_0100;
        end
        @(negedge clk); cyc++;
      end
    end
    sp_in = sp_keep; start = 0;
    chk(got, {nm, " R13 done seen"}, 32'(got), 1);
    chk(n == nexp, {nm, " R11/R12 beat count"}, n, nexp);
    chk(sp_out == e_base(), {nm, " R2 sp_out"}, sp_out, e_base());
    chk(exc_ret == (32'hFFFFFF80 | (32'(is_secure) << 6) | 32'h20 | (32'(!fp_active) << 4)),
        {nm, " R10 exc_ret"}, exc_ret,
        32'hFFFFFF80 | (32'(is_secure) << 6) | 32'h20 | (32'(!fp_active) << 4));
    chk(stack_ok == (err_at < 0 && !(mode == 1 && !cpacr_ok)), {nm, " R8/R12 stack_ok"},
        32'(stack_ok), 32'(err_at < 0 && !(mode == 1 && !cpacr_ok)));
    chk(fault_secure == (mode == 2), {nm, " R5 fault_secure"}, 32'(fault_secure), 32'(mode == 2));
    chk(fault_nocp == (mode == 3 || (mode == 1 && !cpacr_ok && err_at < 0)), {nm, " R6/R8 fault_nocp"},
        32'(fault_nocp), 32'(mode == 3 || (mode == 1 && !cpacr_ok && err_at < 0)));
    chk(fp_clear == (mode == 1 && cpacr_ok && err_at < 0), {nm, " R9 fp_clear"},
        32'(fp_clear), 32'(mode == 1 && cpacr_ok && err_at < 0));
    @(negedge clk);
    chk(!done && !wr_valid, {nm, " R13 done one cycle"}, 32'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_ctl();
    randomize_data();
    repeat (3) @(negedge clk);
    chk(!wr_valid && !done, "reset R11/R13 idle", {30'b0, wr_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);

    clear_ctl(); randomize_data(); sp_in[2:0] = 0;            run_case("nofp R1");
    clear_ctl(); randomize_data(); sp_in[2:0] = 3'b100;       run_case("realign R2");
    clear_ctl(); randomize_data(); sp_in[2:0] = 3'b100; align_req = 0; run_case("noalign R2");
    clear_ctl(); randomize_data(); fp_active = 1; is_secure = 1; fp_treat_secure = 1; sfp_active = 1;
    run_case("big eager R4");
    clear_ctl(); randomize_data(); fp_active = 1; ns_cp10_ok = 1; full_ready = 1; run_case("small eager R4");
    clear_ctl(); randomize_data(); fp_active = 1; is_secure = 1; lazy_pending = 1; has_sec_ext = 1; ns_cp10_ok = 0;
    run_case("secflt R5");
    clear_ctl(); randomize_data(); fp_active = 1; is_secure = 1; lazy_pending = 1; run_case("pend nosec R5");
    clear_ctl(); randomize_data(); fp_active = 1; ns_cp10_ok = 0; run_case("ns nocp R6");
    clear_ctl(); randomize_data(); fp_active = 1; is_secure = 1; lazy_en = 1; run_case("lazy R7");
    clear_ctl(); randomize_data(); fp_active = 1; is_secure = 1; cpacr_ok = 0; run_case("cpacr deny R8");
    clear_ctl(); randomize_data(); fp_active = 1; is_secure = 1; cpacr_ok = 0; err_at = 3;
    run_case("deny err R8");
    clear_ctl(); randomize_data(); fp_active = 1; is_secure = 1; fp_treat_secure = 1; err_at = 30;
    run_case("fp err R12");
    clear_ctl(); randomize_data(); fp_active = 1; is_secure = 1; err_at = 24;
    run_case("fpscr err R9");
    clear_ctl(); randomize_data(); poke = 1; run_case("busy start R13");

    for (int t = 0; t < 60; t++) begin
      clear_ctl(); randomize_data();
      align_req = $urandom; is_secure = $urandom; fp_active = $urandom; sfp_active = $urandom;
      ns_cp10_ok = $urandom; fp_treat_secure = $urandom; lazy_pending = $urandom;
      has_sec_ext = $urandom; lazy_en = $urandom; cpacr_ok = ($urandom % 4) != 0;
      if (($urandom % 6) == 0) err_at = $urandom % e_nominal();
      run_case("random R1");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule